// File: doc/BRIEF.md
# Field Memory Read and Mode Controller

This block sits in front of a vertical reconstruction path. It paces the reading of two external field memories and supplies the line and pixel timing that the filters downstream rely on. The block runs on one fast clock. An internal divide-by-two enable acts as the pixel strobe, so one fast cycle carries a first-field word and the next carries a second-field word. A horizontal reference pulse restarts the pixel count, and a vertical reference pulse restarts the line count.

Two control bits, interpolate and film, select one of four modes: plain bypass, CAMERA, FILM or multi-picture bypass. The mode sets the read-enable, output-enable and read-reset strobes for the memories. It also sets the extra line delay that the reconstruction needs. The parity reported for the upstream field is moved forward by one field so that it matches the data being read. Outside the active window the data outputs carry black luma and neutral chroma.

Top module: `vr_fm_read_ctl`

## Requirements
- R1: `mode_o` is loaded at every pixel strobe from {interp_i, film_i}, coded as follows: 00 gives 0 (bypass), 10 gives 1 (CAMERA), 01 gives 2 (multi-picture) and 11 gives 3 (FILM). It is 0 after reset.
- R2: `pix_stb_o` is low in the first cycle after reset and then changes value on every clock. Control inputs are sampled only in cycles where it is high.
- R3: A fast-cycle counter goes to 0 on the edge that sees a rising horizontal reference at a pixel strobe. It then counts up each cycle and saturates at all ones, which is also its reset value. `pix_cnt_o` is this counter divided by two. On each such edge `line_cnt_o` goes to 0 if a rising vertical reference was seen since the previous horizontal reference, or in the same strobe. Otherwise it increments and saturates at all ones, which is also its reset value.
- R4: Outside multi-picture mode, `re_fm2_o` and `re_fm3_o` are high together. They are high while the fast counter is in [2·LINE_PIX−RE_LEAD, 2·LINE_PIX) or in [0, RE_WIDTH−RE_LEAD). This makes the pulse RE_WIDTH cycles long, starting RE_LEAD cycles before the reference. Both are low while the counter is saturated.
- R5: Outside multi-picture mode, `oe_fm2_o` equals read-enable in cycles where `pix_stb_o` is low, and `oe_fm3_o` equals read-enable in cycles where it is high. The two are never high together.
- R6: In multi-picture mode, `re_fm2_o` and `oe_fm2_o` stay high and the memory-3 strobes stay low. `rstr_o` is high only in the cycle where the fast counter equals RSTR_LAG.
- R7: Outside multi-picture mode, `rstr_o` is a one-cycle pulse in the cycle after the edge that sees a rising vertical reference.
- R8: On a rising vertical reference, `fld_rd_o` takes the parity that `field_even_i` had at the previous rising vertical reference (0 after reset).
- R9: `line_dly_o` is 2 in FILM mode when `fld_rd_o`=0 and 3 when it is 1. It is 3 in CAMERA mode when `fld_rd_o`=0 and 4 when it is 1. It is 0 in both bypass modes.
- R10: When the active window is not met, the value loaded at a pixel strobe is luma 16 and chroma 0. The window is met when the pixel is in [OUT_LAG, OUT_LAG+ACT_PIX) and the line is in [ACT_L0+d, ACT_L0+d+ACT_LINES), where d is `line_dly_o`.
- R11: Inside the window, `y_i`/`uv_i` sampled at a pixel strobe edge appear on `y_o`/`uv_o` right after that edge. In multi-picture mode they appear one pixel strobe later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | fast clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| href_i | input | 1 | horizontal reference |
| vref_i | input | 1 | vertical reference |
| field_even_i | input | 1 | upstream field parity |
| interp_i | input | 1 | interpolation request |
| film_i | input | 1 | film request |
| y_i | input | YW | luma from field memories |
| uv_i | input | CW | chroma from field memories |
| re_fm2_o | output | 1 | read enable, memory 2 |
| re_fm3_o | output | 1 | read enable, memory 3 |
| oe_fm2_o | output | 1 | output enable, memory 2 |
| oe_fm3_o | output | 1 | output enable, memory 3 |
| rstr_o | output | 1 | read reset for both memories |
| pix_stb_o | output | 1 | pixel strobe |
| pix_cnt_o | output | FW-1 | pixel counter |
| line_cnt_o | output | LW | line counter |
| mode_o | output | 2 | decoded mode |
| fld_rd_o | output | 1 | realigned field parity |
| line_dly_o | output | 3 | mode line delay |
| y_o | output | YW | luma out |
| uv_o | output | CW | chroma out |

## Verification
The design is run in all four modes in turn, including CAMERA a second time after FILM. Each mode lasts three fields of alternating parity. This shows whether the delay and the realigned parity track the previous field and not the current one. Comparing multi-picture mode with the other modes shows the fixed memory-2 strobes, the read-reset taken from the counter and the extra pixel of latency. A stretch with no horizontal reference after reset shows that the saturated counters keep every strobe low and the output blanked. The per-line strobe lead and tail, and the window edges, are compared on every clock.

// File: rtl/vr_pkg.sv
package vr_pkg;
  typedef enum logic [1:0] {
    MODE_BYP  = 2'd0,
    MODE_CAM  = 2'd1,
    MODE_MPIC = 2'd2,
    MODE_FILM = 2'd3
  } vr_mode_e;

  function automatic vr_mode_e decode_mode(input logic interp, input logic film);
    case ({interp, film})
      2'b00:   return MODE_BYP;
      2'b10:   return MODE_CAM;
      2'b01:   return MODE_MPIC;
      default: return MODE_FILM;
    endcase
  endfunction
endpackage

// File: rtl/vr_timing.sv
module vr_timing #(
  parameter int FW = 12,
  parameter int LW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          href_i,
  input  logic          vref_i,
  output logic          pix_stb_o,
  output logic          vref_rise_o,
  output logic [FW-1:0] fcnt_o,
  output logic [LW-1:0] line_o
);
  logic phase_q, href_q, vref_q, pend_q, href_rise;

  assign pix_stb_o   = phase_q;
  assign href_rise   = phase_q & href_i & ~href_q;
  assign vref_rise_o = phase_q & vref_i & ~vref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      href_q  <= 1'b0;
      vref_q  <= 1'b0;
      pend_q  <= 1'b0;
      fcnt_o  <= '1;
      line_o  <= '1;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        href_q <= href_i;
        vref_q <= vref_i;
      end
      if (href_rise) fcnt_o <= '0;
      else if (fcnt_o != '1) fcnt_o <= fcnt_o + 1'b1;
      if (href_rise) begin
        pend_q <= 1'b0;
        if (pend_q | vref_rise_o) line_o <= '0;
        else if (line_o != '1) line_o <= line_o + 1'b1;
      end else if (vref_rise_o) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vr_mode_ctl.sv
module vr_mode_ctl
  import vr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pix_stb_i,
  input  logic       vref_rise_i,
  input  logic       interp_i,
  input  logic       film_i,
  input  logic       field_even_i,
  output vr_mode_e   mode_o,
  output logic       fld_rd_o,
  output logic [2:0] dly_o
);
  logic fld_cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= MODE_BYP;
      fld_cap_q <= 1'b0;
      fld_rd_o  <= 1'b0;
    end else begin
      if (pix_stb_i) mode_o <= decode_mode(interp_i, film_i);
      // parity seen upstream is read back one field later
      if (vref_rise_i) begin
        fld_cap_q <= field_even_i;
        fld_rd_o  <= fld_cap_q;
      end
    end
  end

  always_comb begin
    case (mode_o)
      MODE_CAM:  dly_o = fld_rd_o ? 3'd4 : 3'd3;
      MODE_FILM: dly_o = fld_rd_o ? 3'd3 : 3'd2;
      default:   dly_o = 3'd0;
    endcase
  end
endmodule

// File: rtl/vr_strobe_gen.sv
module vr_strobe_gen
  import vr_pkg::*;
#(
  parameter int FW       = 12,
  parameter int LINE_PIX = 1024,
  parameter int RE_LEAD  = 127,
  parameter int RE_WIDTH = 1680,
  parameter int RSTR_LAG = 2016
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_stb_i,
  input  logic          vref_rise_i,
  input  logic [FW-1:0] fcnt_i,
  input  vr_mode_e      mode_i,
  output logic          re_fm2_o,
  output logic          re_fm3_o,
  output logic          oe_fm2_o,
  output logic          oe_fm3_o,
  output logic          rstr_o
);
  localparam logic [FW-1:0] LINE_F = FW'(2 * LINE_PIX);
  localparam logic [FW-1:0] RE_ON  = FW'(2 * LINE_PIX - RE_LEAD);
  localparam logic [FW-1:0] RE_OFF = FW'(RE_WIDTH - RE_LEAD);
  localparam logic [FW-1:0] RS_AT  = FW'(RSTR_LAG);

  logic rstr_q, re_win, mpic;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rstr_q <= 1'b0;
    else         rstr_q <= vref_rise_i;
  end

  assign mpic   = (mode_i == MODE_MPIC);
  // pulse wraps across the reference: lead part, then tail part
  assign re_win = ((fcnt_i >= RE_ON) && (fcnt_i < LINE_F)) || (fcnt_i < RE_OFF);

  assign re_fm2_o = mpic | re_win;
  assign re_fm3_o = ~mpic & re_win;
  assign oe_fm2_o = mpic | (re_win & ~pix_stb_i);
  assign oe_fm3_o = ~mpic & re_win & pix_stb_i;
  assign rstr_o   = mpic ? (fcnt_i == RS_AT) : rstr_q;
endmodule

// File: rtl/vr_blank_path.sv
module vr_blank_path
  import vr_pkg::*;
#(
  parameter int FW        = 12,
  parameter int LW        = 10,
  parameter int YW        = 8,
  parameter int CW        = 4,
  parameter int OUT_LAG   = 80,
  parameter int ACT_PIX   = 720,
  parameter int ACT_L0    = 23,
  parameter int ACT_LINES = 288,
  parameter int BLANK_Y   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_stb_i,
  input  logic [FW-1:0] fcnt_i,
  input  logic [LW-1:0] line_i,
  input  logic [2:0]    dly_i,
  input  vr_mode_e      mode_i,
  input  logic [YW-1:0] y_i,
  input  logic [CW-1:0] uv_i,
  output logic [YW-1:0] y_o,
  output logic [CW-1:0] uv_o
);
  localparam int PW = FW - 1;
  localparam int DW = YW + CW;
  localparam int NSTG = 2;
  localparam logic [PW-1:0] PX_LO = PW'(OUT_LAG);
  localparam logic [PW-1:0] PX_HI = PW'(OUT_LAG + ACT_PIX);
  localparam logic [DW-1:0] BLANK = {YW'(BLANK_Y), CW'(0)};

  logic [PW-1:0] pix;
  logic [LW-1:0] ln_lo, ln_hi;
  logic          win;
  logic [DW-1:0] stg_q [NSTG];

  assign pix   = fcnt_i[FW-1:1];
  assign ln_lo = LW'(ACT_L0) + LW'(dly_i);
  assign ln_hi = ln_lo + LW'(ACT_LINES);
  assign win   = (pix >= PX_LO) && (pix < PX_HI) && (line_i >= ln_lo) && (line_i < ln_hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stg_q[0] <= BLANK;
    else if (pix_stb_i) stg_q[0] <= win ? {y_i, uv_i} : BLANK;
  end

  for (genvar g = 1; g < NSTG; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        stg_q[g] <= BLANK;
      else if (pix_stb_i) stg_q[g] <= stg_q[g-1];
    end
  end

  assign {y_o, uv_o} = (mode_i == MODE_MPIC) ? stg_q[NSTG-1] : stg_q[0];
endmodule

// File: rtl/vr_fm_read_ctl.sv
module vr_fm_read_ctl
  import vr_pkg::*;
#(
  parameter int LINE_PIX  = 1024,
  parameter int RE_LEAD   = 127,
  parameter int RE_WIDTH  = 1680,
  parameter int RSTR_LAG  = 2016,
  parameter int OUT_LAG   = 80,
  parameter int ACT_PIX   = 720,
  parameter int ACT_L0    = 23,
  parameter int ACT_LINES = 288,
  parameter int LW        = 10,
  parameter int YW        = 8,
  parameter int CW        = 4,
  localparam int FW       = $clog2(LINE_PIX) + 2,
  localparam int PW       = FW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          href_i,
  input  logic          vref_i,
  input  logic          field_even_i,
  input  logic          interp_i,
  input  logic          film_i,
  input  logic [YW-1:0] y_i,
  input  logic [CW-1:0] uv_i,
  output logic          re_fm2_o,
  output logic          re_fm3_o,
  output logic          oe_fm2_o,
  output logic          oe_fm3_o,
  output logic          rstr_o,
  output logic          pix_stb_o,
  output logic [PW-1:0] pix_cnt_o,
  output logic [LW-1:0] line_cnt_o,
  output logic [1:0]    mode_o,
  output logic          fld_rd_o,
  output logic [2:0]    line_dly_o,
  output logic [YW-1:0] y_o,
  output logic [CW-1:0] uv_o
);
  logic          vref_rise;
  logic [FW-1:0] fcnt;
  vr_mode_e      mode;

  vr_timing #(.FW(FW), .LW(LW)) u_timing (
    .clk_i, .rst_ni, .href_i, .vref_i,
    .pix_stb_o, .vref_rise_o(vref_rise), .fcnt_o(fcnt), .line_o(line_cnt_o)
  );

  vr_mode_ctl u_mode (
    .clk_i, .rst_ni, .pix_stb_i(pix_stb_o), .vref_rise_i(vref_rise),
    .interp_i, .film_i, .field_even_i,
    .mode_o(mode), .fld_rd_o, .dly_o(line_dly_o)
  );

  vr_strobe_gen #(
    .FW(FW), .LINE_PIX(LINE_PIX), .RE_LEAD(RE_LEAD),
    .RE_WIDTH(RE_WIDTH), .RSTR_LAG(RSTR_LAG)
  ) u_strobe (
    .clk_i, .rst_ni, .pix_stb_i(pix_stb_o), .vref_rise_i(vref_rise),
    .fcnt_i(fcnt), .mode_i(mode),
    .re_fm2_o, .re_fm3_o, .oe_fm2_o, .oe_fm3_o, .rstr_o
  );

  vr_blank_path #(
    .FW(FW), .LW(LW), .YW(YW), .CW(CW), .OUT_LAG(OUT_LAG),
    .ACT_PIX(ACT_PIX), .ACT_L0(ACT_L0), .ACT_LINES(ACT_LINES)
  ) u_blank (
    .clk_i, .rst_ni, .pix_stb_i(pix_stb_o), .fcnt_i(fcnt), .line_i(line_cnt_o),
    .dly_i(line_dly_o), .mode_i(mode), .y_i, .uv_i, .y_o, .uv_o
  );

  assign pix_cnt_o = fcnt[FW-1:1];
  assign mode_o    = mode;
endmodule

// File: rtl/vr_fm_read_ctl_chk.sv
module vr_fm_read_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       re_fm2_o,
  input logic       re_fm3_o,
  input logic       oe_fm2_o,
  input logic       oe_fm3_o,
  input logic       rstr_o,
  input logic       pix_stb_o,
  input logic [1:0] mode_o,
  input logic [2:0] line_dly_o
);
  // R2
  stb_toggle_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_stb_o |=> !pix_stb_o);
  // R2
  stb_toggle_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_stb_o |=> pix_stb_o);
  // R4
  re_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd2) |-> (re_fm2_o == re_fm3_o));
  // R5
  oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(oe_fm2_o && oe_fm3_o));
  // R6
  mpic_fm3_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2) |-> (re_fm2_o && oe_fm2_o && !re_fm3_o && !oe_fm3_o));
  // R7
  rstr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rstr_o |=> !rstr_o);
  // R9
  byp_no_dly_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 || mode_o == 2'd2) |-> (line_dly_o == 3'd0));
endmodule

bind vr_fm_read_ctl vr_fm_read_ctl_chk u_chk (
  .clk_i, .rst_ni, .re_fm2_o, .re_fm3_o, .oe_fm2_o, .oe_fm3_o,
  .rstr_o, .pix_stb_o, .mode_o, .line_dly_o
);

// File: tb/tb_vr_fm_read_ctl.sv
module tb_vr_fm_read_ctl;
  localparam int LP = 64;
  localparam int LF = 2 * LP;
  localparam int RL = 7;
  localparam int RW = 100;
  localparam int RS = 120;
  localparam int OL = 8;
  localparam int AP = 40;
  localparam int AL0 = 2;
  localparam int ALN = 5;
  localparam int FSAT = 255;
  localparam int LSAT = 1023;

  logic clk = 1'b0, rst_n = 1'b0;
  logic href = 1'b0, vref = 1'b0, fev = 1'b0, interp = 1'b0, film = 1'b0;
  logic [7:0] y_i = '0;
  logic [3:0] uv_i = '0;
  logic re2, re3, oe2, oe3, rstr, stb, fld;
  logic [6:0] pix;
  logic [9:0] line;
  logic [1:0] mode;
  logic [2:0] dly;
  logic [7:0] y_o;
  logic [3:0] uv_o;

  int errors = 0, checks = 0, cyc = 0;
  bit running = 0, done = 0;

  always #10 clk = ~clk;

  vr_fm_read_ctl #(
    .LINE_PIX(LP), .RE_LEAD(RL), .RE_WIDTH(RW), .RSTR_LAG(RS), .OUT_LAG(OL),
    .ACT_PIX(AP), .ACT_L0(AL0), .ACT_LINES(ALN)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .href_i(href), .vref_i(vref), .field_even_i(fev),
    .interp_i(interp), .film_i(film), .y_i(y_i), .uv_i(uv_i),
    .re_fm2_o(re2), .re_fm3_o(re3), .oe_fm2_o(oe2), .oe_fm3_o(oe3), .rstr_o(rstr),
    .pix_stb_o(stb), .pix_cnt_o(pix), .line_cnt_o(line), .mode_o(mode),
    .fld_rd_o(fld), .line_dly_o(dly), .y_o(y_o), .uv_o(uv_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference state
  int m_ph, m_hq, m_vq, m_fc, m_ln, m_pend, m_fcap, m_frd, m_md, m_rq;
  int m_s1y, m_s1u, m_s2y, m_s2u;

  function automatic int f_dly(int md, int frd);
    if (md == 1) return frd ? 4 : 3;
    if (md == 3) return frd ? 3 : 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_hq = 0; m_vq = 0; m_fc = FSAT; m_ln = LSAT; m_pend = 0;
      m_fcap = 0; m_frd = 0; m_md = 0; m_rq = 0;
      m_s1y = 16; m_s1u = 0; m_s2y = 16; m_s2u = 0;
    end else begin
      int hr, vr, d, px, win, n_md;
      hr = m_ph && href && !m_hq;
      vr = m_ph && vref && !m_vq;
      d  = f_dly(m_md, m_frd);
      px = m_fc / 2;
      win = (px >= OL) && (px < OL + AP) && (m_ln >= AL0 + d) && (m_ln < AL0 + d + ALN);
      n_md = interp ? (film ? 3 : 1) : (film ? 2 : 0);
      if (m_ph) begin
        m_s2y = m_s1y; m_s2u = m_s1u;
        m_s1y = win ? int'(y_i) : 16;
        m_s1u = win ? int'(uv_i) : 0;
        m_hq = href; m_vq = vref; m_md = n_md;
      end
      m_rq = vr;
      if (vr) begin m_frd = m_fcap; m_fcap = fev; end
      if (hr) begin
        m_ln = (m_pend || vr) ? 0 : (m_ln == LSAT ? LSAT : m_ln + 1);
        m_pend = 0;
      end else if (vr) m_pend = 1;
      m_fc = hr ? 0 : (m_fc == FSAT ? FSAT : m_fc + 1);
      m_ph = !m_ph;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && running) begin
      int e_re, e_mp, e_rs;
      e_mp = (m_md == 2);
      e_re = e_mp ? 1 : int'(((m_fc >= LF - RL) && (m_fc < LF)) || (m_fc < RW - RL));
      e_rs = e_mp ? int'(m_fc == RS) : m_rq;
      chk(mode == 2'(m_md), "R1 mode", mode, m_md);
      chk(stb == m_ph[0], "R2 pix_stb", stb, m_ph);
      chk(pix == 7'(m_fc / 2), "R3 pix_cnt", pix, m_fc / 2);
      chk(line == 10'(m_ln), "R3 line_cnt", line, m_ln);
      chk(re2 == e_re[0], "R4 re_fm2", re2, e_re);
      chk(re3 == (e_re[0] && !e_mp[0]), "R4 re_fm3", re3, e_re && !e_mp);
      chk(oe2 == (e_mp[0] || (e_re[0] && !m_ph[0])), "R5 oe_fm2", oe2, e_mp || (e_re && !m_ph));
      chk(oe3 == (!e_mp[0] && e_re[0] && m_ph[0]), "R5 oe_fm3", oe3, !e_mp && e_re && m_ph);
      chk(rstr == e_rs[0], e_mp ? "R6 rstr" : "R7 rstr", rstr, e_rs);
      chk(fld == m_frd[0], "R8 fld_rd", fld, m_frd);
      chk(dly == 3'(f_dly(m_md, m_frd)), "R9 line_dly", dly, f_dly(m_md, m_frd));
      chk(y_o == 8'(e_mp ? m_s2y : m_s1y), "R10 R11 y_o", y_o, e_mp ? m_s2y : m_s1y);
      chk(uv_o == 4'(e_mp ? m_s2u : m_s1u), "R10 R11 uv_o", uv_o, e_mp ? m_s2u : m_s1u);
    end
    y_i  <= 8'(cyc * 7 + 3);
    uv_i <= 4'(cyc);
  end

  task automatic run_line(input bit v);
    @(negedge clk);
    href = 1'b1; vref = v;
    repeat (8) @(negedge clk);
    href = 1'b0; vref = 1'b0;
    repeat (LF - 9) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    bit [1:0] seq [5] = '{2'b00, 2'b10, 2'b01, 2'b11, 2'b10};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, before any reference
    chk(y_o == 8'd16, "R10 reset luma", y_o, 16);
    chk(uv_o == 4'd0, "R10 reset chroma", uv_o, 0);
    chk(line == 10'h3ff, "R3 reset line", line, LSAT);
    chk(mode == 2'd0, "R1 reset mode", mode, 0);
    chk(!re2 && !re3, "R4 reset re", re2, 0);
    running = 1;
    repeat (300) @(negedge clk);
    chk(!re2 && !rstr, "R4 idle saturated", re2, 0);
    for (int m = 0; m < 5; m++) begin
      {interp, film} = seq[m];
      repeat (4) @(negedge clk);
      chk(mode == ((seq[m] == 2'b00) ? 2'd0 : (seq[m] == 2'b10) ? 2'd1 :
                   (seq[m] == 2'b01) ? 2'd2 : 2'd3), "R1 decode", mode, seq[m]);
      for (int f = 0; f < 3; f++) begin
        fev = ~fev;
        for (int l = 0; l < 12; l++) run_line(l == 0);
      end
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule